// File: doc/BRIEF.md
# Interface timing sweep controller

This block runs an automatic calibration sweep against a high-speed source-synchronous receiver that has three delay controls: a sample-point code, a setup-delay code and a hold-delay code. For every sample-point code it first writes setup and hold to zero and reads a one-bit phase status as the baseline. It then measures two margins, one at a time. For the hold margin it raises the hold code from 1 with setup at zero until the status differs from the baseline. For the setup margin it puts hold back to zero and raises the setup code from 1 in the same way. Each margin saturates at 15 when no code changes the status.

The target's registers are reached through a simple request/acknowledge port, with one register operation per handshake. After each register write, the controller waits a programmable number of cycles before the next operation, so the receiver can settle. Results go into one array entry per sample-point code. Each entry holds the baseline bit, the setup count and the hold count, and a combinational read port indexed by sample-point code returns it. The choice of a final operating point from the array is left to other logic.

Top module: `timing_sweep_ctrl`

## Requirements
- R1: While rst_ni is low, busy_o, done_o and reg_req_o are 0.
- R2: A start_i pulse while idle raises busy_o on the next cycle. busy_o stays high until the sweep ends. done_o is a one-cycle pulse in the first cycle after busy_o falls, and busy_o never falls without it.
- R3: For each sample point, the controller writes the sample code (reg_sel_o = 0), then setup = 0 (reg_sel_o = 1), then hold = 0 (reg_sel_o = 2), then reads the status (reg_we_o = 0, reg_sel_o = 3, bit in reg_rdata_i). That read value is stored as the entry's baseline bit.
- R4: With setup at 0, hold codes 1, 2, 3, ... are written, each followed by a status read. The first code whose read differs from the baseline is stored as the hold result. A nonzero hold code is never written while the last written setup code is nonzero.
- R5: After the hold search, hold is written back to 0. Setup codes 1, 2, 3, ... are then written and read in the same way, and the first toggling code is stored as the setup result. A nonzero setup code is never written while the last written hold code is nonzero.
- R6: Setup and hold codes are 4 bits. If code 15 does not toggle the status, the stored result for that field is 15.
- R7: Sample codes are written in the order 0, 1, ..., 31, once each per sweep, giving 32 entries.
- R8: After every register write is acknowledged, at least settle_cyc_i cycles pass before the next request rises.
- R9: reg_req_o, once raised, stays high with reg_we_o, reg_sel_o and reg_wdata_o unchanged until reg_ack_i is seen, and falls in the following cycle.
- R10: rd_seek_o, rd_setup_o and rd_hold_o return the entry of sample code rd_idx_i from the most recent sweep.
- R11: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sweep when idle |
| settle_cyc_i | input | 8 | Wait in cycles after each register write |
| busy_o | output | 1 | High for the whole sweep |
| done_o | output | 1 | One-cycle completion pulse |
| reg_req_o | output | 1 | Register operation request |
| reg_we_o | output | 1 | 1 = write, 0 = status read |
| reg_sel_o | output | 2 | 0 sample, 1 setup, 2 hold, 3 status |
| reg_wdata_o | output | 5 | Write data (code) |
| reg_ack_i | input | 1 | Target acknowledge, one cycle |
| reg_rdata_i | input | 1 | Status bit, valid with reg_ack_i on reads |
| rd_idx_i | input | 5 | Result array read index |
| rd_seek_o | output | 1 | Stored baseline bit |
| rd_setup_o | output | 4 | Stored setup result |
| rd_hold_o | output | 4 | Stored hold result |

## Verification
The bench models a target whose status bit has a baseline per sample code and toggles once hold reaches one threshold with setup at zero, or once setup reaches another threshold with hold at zero. Thresholds that start at 1, sit in the middle of the range and lie beyond 15 tell a correct first-toggle search apart from an off-by-one, a search that compares against the wrong reference, and a missing saturation. Two sweeps use different threshold patterns, settle counts of 5 and 0, and acknowledge latencies of 0 to 2 cycles. A start pulse given in the middle of a sweep shows whether the sample-code order is restarted.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef enum logic [1:0] {
    SEL_SMP  = 2'd0,
    SEL_SET  = 2'd1,
    SEL_HLD  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    B_IDLE,
    B_REQ,
    B_SETTLE,
    B_FIN
  } bus_state_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_W_SMP,
    S_W_SET0,
    S_W_HLD0,
    S_RD_BASE,
    S_W_HLD,
    S_RD_HLD,
    S_W_HLD_CLR,
    S_W_SET,
    S_RD_SET,
    S_STORE
  } seq_state_e;

endpackage

// File: rtl/tsw_bus_port.sv
module tsw_bus_port #(
  parameter int DATA_W   = 5,
  parameter int SETTLE_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_valid_i,
  input  logic                 op_we_i,
  input  tsw_pkg::reg_sel_e    op_sel_i,
  input  logic [DATA_W-1:0]    op_wdata_i,
  input  logic [SETTLE_W-1:0]  settle_cyc_i,
  output logic                 op_done_o,
  output logic                 op_rdata_o,
  output logic                 reg_req_o,
  output logic                 reg_we_o,
  output tsw_pkg::reg_sel_e    reg_sel_o,
  output logic [DATA_W-1:0]    reg_wdata_o,
  input  logic                 reg_ack_i,
  input  logic                 reg_rdata_i
);
  import tsw_pkg::*;

  localparam int GAP_W = SETTLE_W + 1;

  bus_state_e          st_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic                req_q, we_q, rdata_q;
  reg_sel_e            sel_q;
  logic [DATA_W-1:0]   wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      sel_q   <= SEL_SMP;
      wdata_q <= '0;
      rdata_q <= 1'b0;
    end else begin
      case (st_q)
        B_IDLE: if (op_valid_i) begin
          req_q   <= 1'b1;
          we_q    <= op_we_i;
          sel_q   <= op_sel_i;
          wdata_q <= op_wdata_i;
          st_q    <= B_REQ;
        end
        B_REQ: if (reg_ack_i) begin
          req_q <= 1'b0;
          if (!we_q) rdata_q <= reg_rdata_i;
          if (we_q && settle_cyc_i != '0) begin
            cnt_q <= settle_cyc_i - SETTLE_W'(1);
            st_q  <= B_SETTLE;
          end else begin
            st_q <= B_FIN;
          end
        end
        B_SETTLE: begin
          if (cnt_q == '0) st_q <= B_FIN;
          else             cnt_q <= cnt_q - SETTLE_W'(1);
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign op_done_o   = (st_q == B_FIN);
  assign op_rdata_o  = rdata_q;
  assign reg_req_o   = req_q;
  assign reg_we_o    = we_q;
  assign reg_sel_o   = sel_q;
  assign reg_wdata_o = wdata_q;

  // independent cycle count since the last acknowledged write
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          gap_q <= '1;
    else if (req_q && reg_ack_i && we_q)  gap_q <= '0;
    else if (gap_q != '1)                 gap_q <= gap_q + GAP_W'(1);
  end

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_we_o) &&
      $stable(reg_sel_o) && $stable(reg_wdata_o));

  // R9
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_ack_i |=> !reg_req_o);

  // R8
  settle_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_req_o) |-> gap_q >= {1'b0, settle_cyc_i});

endmodule

// File: rtl/tsw_seq.sv
module tsw_seq #(
  parameter int NUM_PTS = 32,
  parameter int IDX_W   = 5,
  parameter int CODE_W  = 4,
  parameter int DATA_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               op_valid_o,
  output logic               op_we_o,
  output tsw_pkg::reg_sel_e  op_sel_o,
  output logic [DATA_W-1:0]  op_wdata_o,
  input  logic               op_done_i,
  input  logic               op_rdata_i,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic               wr_seek_o,
  output logic [CODE_W-1:0]  wr_setup_o,
  output logic [CODE_W-1:0]  wr_hold_o
);
  import tsw_pkg::*;

  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_PTS - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  smp_q;
  logic [CODE_W-1:0] code_q, setup_q, hold_q;
  logic              base_q, done_q;
  logic              toggled, stop;

  assign toggled = op_rdata_i != base_q;
  assign stop    = toggled || (code_q == CODE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      smp_q   <= '0;
      code_q  <= '0;
      setup_q <= '0;
      hold_q  <= '0;
      base_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          smp_q   <= '0;
          state_q <= S_W_SMP;
        end
        S_W_SMP:  if (op_done_i) state_q <= S_W_SET0;
        S_W_SET0: if (op_done_i) state_q <= S_W_HLD0;
        S_W_HLD0: if (op_done_i) state_q <= S_RD_BASE;
        S_RD_BASE: if (op_done_i) begin
          base_q  <= op_rdata_i;
          code_q  <= CODE_ONE;
          state_q <= S_W_HLD;
        end
        S_W_HLD: if (op_done_i) state_q <= S_RD_HLD;
        S_RD_HLD: if (op_done_i) begin
          if (stop) begin
            hold_q  <= code_q;
            state_q <= S_W_HLD_CLR;
          end else begin
            code_q  <= code_q + CODE_ONE;
            state_q <= S_W_HLD;
          end
        end
        S_W_HLD_CLR: if (op_done_i) begin
          code_q  <= CODE_ONE;
          state_q <= S_W_SET;
        end
        S_W_SET: if (op_done_i) state_q <= S_RD_SET;
        S_RD_SET: if (op_done_i) begin
          if (stop) begin
            setup_q <= code_q;
            state_q <= S_STORE;
          end else begin
            code_q  <= code_q + CODE_ONE;
            state_q <= S_W_SET;
          end
        end
        S_STORE: begin
          if (smp_q == LAST_IDX) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            smp_q   <= smp_q + IDX_W'(1);
            state_q <= S_W_SMP;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    op_valid_o = 1'b1;
    op_we_o    = 1'b1;
    op_sel_o   = SEL_STAT;
    op_wdata_o = '0;
    case (state_q)
      S_W_SMP:     begin op_sel_o = SEL_SMP; op_wdata_o = DATA_W'(smp_q); end
      S_W_SET0:    op_sel_o = SEL_SET;
      S_W_HLD0:    op_sel_o = SEL_HLD;
      S_W_HLD:     begin op_sel_o = SEL_HLD; op_wdata_o = DATA_W'(code_q); end
      S_W_HLD_CLR: op_sel_o = SEL_HLD;
      S_W_SET:     begin op_sel_o = SEL_SET; op_wdata_o = DATA_W'(code_q); end
      S_RD_BASE, S_RD_HLD, S_RD_SET: op_we_o = 1'b0;
      default:     begin op_valid_o = 1'b0; op_we_o = 1'b0; end
    endcase
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign wr_en_o    = (state_q == S_STORE);
  assign wr_idx_o   = smp_q;
  assign wr_seek_o  = base_q;
  assign wr_setup_o = setup_q;
  assign wr_hold_o  = hold_q;

  // R2
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R11
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && wr_en_o && (wr_idx_o != LAST_IDX)
      |=> wr_idx_o == $past(wr_idx_o) + IDX_W'(1));

endmodule

// File: rtl/tsw_result_array.sv
module tsw_result_array #(
  parameter int NUM_PTS = 32,
  parameter int IDX_W   = 5,
  parameter int CODE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_seek_i,
  input  logic [CODE_W-1:0] wr_setup_i,
  input  logic [CODE_W-1:0] wr_hold_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_seek_o,
  output logic [CODE_W-1:0] rd_setup_o,
  output logic [CODE_W-1:0] rd_hold_o
);
  localparam int ENT_W = 1 + 2 * CODE_W;

  logic [ENT_W-1:0] ent_q [NUM_PTS];

  for (genvar i = 0; i < NUM_PTS; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ent_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(i))
        ent_q[i] <= {wr_seek_i, wr_setup_i, wr_hold_i};
    end
  end

  assign {rd_seek_o, rd_setup_o, rd_hold_o} = ent_q[rd_idx_i];

endmodule

// File: rtl/timing_sweep_ctrl.sv
module timing_sweep_ctrl #(
  parameter int NUM_PTS  = 32,
  parameter int CODE_W   = 4,
  parameter int SETTLE_W = 8,
  localparam int IDX_W   = $clog2(NUM_PTS),
  localparam int DATA_W  = (IDX_W > CODE_W) ? IDX_W : CODE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cyc_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                reg_req_o,
  output logic                reg_we_o,
  output logic [1:0]          reg_sel_o,
  output logic [DATA_W-1:0]   reg_wdata_o,
  input  logic                reg_ack_i,
  input  logic                reg_rdata_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic                rd_seek_o,
  output logic [CODE_W-1:0]   rd_setup_o,
  output logic [CODE_W-1:0]   rd_hold_o
);
  import tsw_pkg::*;

  logic              op_valid, op_we, op_done, op_rdata;
  reg_sel_e          op_sel, bus_sel;
  logic [DATA_W-1:0] op_wdata;
  logic              wr_en, wr_seek;
  logic [IDX_W-1:0]  wr_idx;
  logic [CODE_W-1:0] wr_setup, wr_hold;

  tsw_seq #(
    .NUM_PTS(NUM_PTS), .IDX_W(IDX_W), .CODE_W(CODE_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .busy_o, .done_o,
    .op_valid_o(op_valid), .op_we_o(op_we), .op_sel_o(op_sel),
    .op_wdata_o(op_wdata), .op_done_i(op_done), .op_rdata_i(op_rdata),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_seek_o(wr_seek),
    .wr_setup_o(wr_setup), .wr_hold_o(wr_hold)
  );

  tsw_bus_port #(.DATA_W(DATA_W), .SETTLE_W(SETTLE_W)) u_bus (
    .clk_i, .rst_ni,
    .op_valid_i(op_valid), .op_we_i(op_we), .op_sel_i(op_sel),
    .op_wdata_i(op_wdata), .settle_cyc_i,
    .op_done_o(op_done), .op_rdata_o(op_rdata),
    .reg_req_o, .reg_we_o, .reg_sel_o(bus_sel), .reg_wdata_o,
    .reg_ack_i, .reg_rdata_i
  );

  assign reg_sel_o = bus_sel;

  tsw_result_array #(.NUM_PTS(NUM_PTS), .IDX_W(IDX_W), .CODE_W(CODE_W)) u_arr (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_seek_i(wr_seek),
    .wr_setup_i(wr_setup), .wr_hold_i(wr_hold),
    .rd_idx_i, .rd_seek_o, .rd_setup_o, .rd_hold_o
  );

  // last acknowledged delay codes, seen from the register port
  logic [DATA_W-1:0] last_set_q, last_hld_q;
  logic              wr_ack;
  assign wr_ack = reg_req_o && reg_ack_i && reg_we_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_set_q <= '0;
      last_hld_q <= '0;
    end else if (wr_ack) begin
      if (bus_sel == SEL_SET) last_set_q <= reg_wdata_o;
      if (bus_sel == SEL_HLD) last_hld_q <= reg_wdata_o;
    end
  end

  // R4
  hold_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_we_o && bus_sel == SEL_HLD && reg_wdata_o != '0
      |-> last_set_q == '0);

  // R5
  setup_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_we_o && bus_sel == SEL_SET && reg_wdata_o != '0
      |-> last_hld_q == '0);

  // R6
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_we_o && bus_sel != SEL_SMP |-> reg_wdata_o < DATA_W'(16));

endmodule

// File: tb/timing_sweep_ctrl_test.sv
`timescale 1ns/1ps
module timing_sweep_ctrl_test;
  localparam int NP = 32;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] settle_cyc_i = 8'd0;
  logic       busy_o, done_o, reg_req_o, reg_we_o;
  logic [1:0] reg_sel_o;
  logic [4:0] reg_wdata_o;
  logic       reg_ack_i = 1'b0;
  logic       reg_rdata_i = 1'b0;
  logic [4:0] rd_idx_i = '0;
  logic       rd_seek_o;
  logic [3:0] rd_setup_o, rd_hold_o;

  always #2.5 clk = ~clk;

  timing_sweep_ctrl uut (
    .clk_i(clk), .rst_ni, .start_i, .settle_cyc_i, .busy_o, .done_o,
    .reg_req_o, .reg_we_o, .reg_sel_o, .reg_wdata_o, .reg_ack_i, .reg_rdata_i,
    .rd_idx_i, .rd_seek_o, .rd_setup_o, .rd_hold_o
  );

  int n_chk = 0, n_fail = 0;
  int variant = 0, settle_val = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // target model: baseline per sample code, one toggle threshold per delay
  function automatic int base_f(int v, int s); return ((s + 3*v + 2) >> 3) & 1; endfunction
  function automatic int th_f(int v, int s);   return (s*(3+v) + 5*v) % 17 + 1; endfunction
  function automatic int ts_f(int v, int s);   return (s*(5+2*v) + 2) % 19 + 1; endfunction
  function automatic int seek_f(int v, int s, int su, int hd);
    int r = base_f(v, s);
    if (su == 0 && hd >= th_f(v, s)) r ^= 1;
    if (hd == 0 && su >= ts_f(v, s)) r ^= 1;
    return r;
  endfunction

  int t_smp = 0, t_set = 0, t_hld = 0;
  int lat_cnt = 0, lat_sel = 0, gap = 1000;
  int hs_bad = 0, settle_bad = 0, exp_smp = 0;
  bit prev_req = 0, prev_we = 0;
  logic [1:0] prev_sel = '0;
  logic [4:0] prev_wd = '0;

  always @(negedge clk) begin
    bit was_ack;
    was_ack = reg_ack_i;
    if (gap < 1000) gap++;
    if (prev_req && !reg_req_o && !was_ack) hs_bad++;
    if (prev_req && reg_req_o && !was_ack &&
        (reg_we_o != prev_we || reg_sel_o != prev_sel || reg_wdata_o != prev_wd)) hs_bad++;
    if (was_ack) begin
      reg_ack_i = 1'b0;
    end else if (reg_req_o) begin
      if (!prev_req && gap < settle_val) settle_bad++;
      if (lat_cnt >= lat_sel % 3) begin
        lat_cnt = 0;
        lat_sel++;
        reg_ack_i = 1'b1;
        if (reg_we_o) begin
          gap = 0;
          case (reg_sel_o)
            2'd0: begin
              // R7 sample codes ascend from 0, once each
              chk(int'(reg_wdata_o) == exp_smp, "R7", "sample code write", reg_wdata_o, exp_smp);
              exp_smp++;
              t_smp = reg_wdata_o;
            end
            2'd1: t_set = reg_wdata_o[3:0];
            2'd2: t_hld = reg_wdata_o[3:0];
            default: ;
          endcase
        end else begin
          reg_rdata_i = 1'(seek_f(variant, t_smp, t_set, t_hld));
        end
      end else begin
        lat_cnt++;
      end
    end
    prev_req = reg_req_o; prev_we = reg_we_o; prev_sel = reg_sel_o; prev_wd = reg_wdata_o;
  end

  // busy/done monitor
  int done_cnt = 0, busy_drop_bad = 0;
  bit prev_busy = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done_o) done_cnt++;
      if (done_o && busy_o) busy_drop_bad++;
      if (prev_busy && !busy_o && !done_o) busy_drop_bad++;
    end
    prev_busy = busy_o;
  end

  // scoreboard
  typedef struct { int idx; int seek; int su; int hd; } exp_t;
  exp_t exp_q[$];
  int sweeps_seen = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && done_o) begin
        while (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          rd_idx_i = 5'(e.idx);
          #1;
          // R10 indexed read; R3 baseline
          chk(int'(rd_seek_o) == e.seek, "R3/R10", $sformatf("baseline idx %0d", e.idx), rd_seek_o, e.seek);
          chk(int'(rd_hold_o) == e.hd, (e.hd == 15) ? "R6/R4" : "R4",
              $sformatf("hold idx %0d", e.idx), rd_hold_o, e.hd);
          chk(int'(rd_setup_o) == e.su, (e.su == 15) ? "R6/R5" : "R5",
              $sformatf("setup idx %0d", e.idx), rd_setup_o, e.su);
        end
        sweeps_seen++;
      end
    end
  end

  task automatic run_sweep(int v, int s);
    int th, ts;
    variant = v; settle_val = s; settle_cyc_i = 8'(s);
    exp_smp = 0; settle_bad = 0; hs_bad = 0; done_cnt = 0; busy_drop_bad = 0;
    for (int i = NP - 1; i >= 0; i--) begin
      exp_t e;
      th = th_f(v, i); ts = ts_f(v, i);
      e.idx = i; e.seek = base_f(v, i);
      e.hd = (th > 15) ? 15 : th;
      e.su = (ts > 15) ? 15 : ts;
      exp_q.push_back(e);
    end
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    repeat (300) @(negedge clk);
    // R11 start during a sweep must not restart it
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R11", "busy during sweep", busy_o, 1);
    wait (sweeps_seen == v + 1);
    @(negedge clk);
    chk(exp_smp == NP, "R7/R11", "sample code writes", exp_smp, NP);
    chk(done_cnt == 1, "R2", "done pulses", done_cnt, 1);
    chk(busy_drop_bad == 0, "R2", "busy fall without done", busy_drop_bad, 0);
    chk(busy_o == 1'b0, "R2", "idle after sweep", busy_o, 0);
    chk(settle_bad == 0, "R8", "settle violations", settle_bad, 0);
    chk(hs_bad == 0, "R9", "handshake violations", hs_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
    chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    chk(reg_req_o == 1'b0, "R1", "req in reset", reg_req_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    run_sweep(0, 5);
    run_sweep(1, 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule